// File: doc/BRIEF.md
# Real-Time Trace Status Port

This block drives a parallel trace port of two 4-bit lanes toward an external debug probe. The status lane reports what the pipeline did in each core cycle: idle, an instruction retired, the first beat of a data stream, or halted. The data lane shows the register-breakpoint status word when nothing else is pending. When a capture has been queued, the data lane instead shows that value one nibble per cycle.

Captures come from two sources. Optional address or operand captures are taken only while the capture-enable bit of the control register is set. An explicit write-debug-data instruction is always taken, and it is stalled rather than lost when there is no room. A breakpoint request halts the core at the next instruction retirement. A strobe whose rising edge falls at mid-cycle tells the probe when to sample both lanes.

Top module: `trace_port`

## Requirements
- R1: `pstOut` and `ddOut` are registers that load a new value at every rising clock edge. Both read 0x0 while `rstN` is low.
- R2: When the port is not halted and no stream starts in a cycle, `pstOut` shows 0x1 if `instDone` was high at that edge and 0x0 if it was low.
- R3: A `brkReq` pulse arms a pending halt. The halt takes effect at the first edge where `instDone` is high; that edge may be the same as the request edge. That edge still reports 0x1, and `pstOut` reads 0xF from the next edge until one edge after `resumeReq` has been sampled high. `resumeReq` also clears a pending halt. `brkReq` and `instDone` have no effect while the port is halted.
- R4: When no stream is active, or while the port is halted, `ddOut` shows the value of `bkptStatus` sampled at that edge.
- R5: A `capValid` request is accepted only while `capEnable` is 1. When `capEnable` is 0 the request has no visible effect on either lane.
- R6: A `wddValid` request is accepted whatever the value of `capEnable`. If both requests arrive in the same cycle, only the `wddValid` one is kept and the optional one is dropped.
- R7: An accepted value of DATA_W bits is sent as DATA_W/4 nibbles on consecutive edges, least significant nibble first. The first nibble appears on `ddOut` two edges after the request edge. On that same first-nibble edge, `pstOut` shows the marker `{2'b10, size}`, where size is the 2-bit size code given with the request; the marker takes precedence over the retire code. Streams that are already queued follow each other with no gap.
- R8: Up to Q_DEPTH accepted requests wait in a queue. While the queue is full, `wddStall` equals `wddValid`, a stalled write-debug-data request is not taken, and an optional request is dropped.
- R9: While the port is halted, an active stream is frozen. After resume, the stream continues with the next unsent nibble.
- R10: `trcStrobe` is low during the first half of each clock period and high during the second half, so its rising edge falls mid-way through each valid lane interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instDone | input | 1 | An instruction retired this cycle |
| brkReq | input | 1 | Breakpoint (halt) request |
| resumeReq | input | 1 | Leave the halted state |
| capEnable | input | 1 | Capture-enable bit of the control register |
| capValid | input | 1 | Optional address/operand capture request |
| capSize | input | 2 | Size code of the optional capture |
| capData | input | DATA_W | Optional capture value |
| wddValid | input | 1 | Write-debug-data instruction request |
| wddSize | input | 2 | Size code of the write-debug-data operand |
| wddData | input | DATA_W | Write-debug-data operand |
| wddStall | output | 1 | Write-debug-data request refused this cycle |
| bkptStatus | input | 4 | Register-breakpoint status shown by default |
| pstOut | output | 4 | Pipeline status lane |
| ddOut | output | 4 | Debug data lane |
| trcStrobe | output | 1 | Mid-cycle sampling strobe for the probe |

## Verification
The bench builds the block with DATA_W = 16 and Q_DEPTH = 2. Each stream is then only four nibbles long, and three back-to-back requests are enough to fill the queue. That small setting lets the bench sweep every size code across several data patterns and every breakpoint status value. It also puts the full-queue drop, the write-debug-data stall, and a halt in the middle of a stream within a few dozen cycles, where each expected nibble can be worked out by hand from the request edge.

// File: rtl/trace_pkg.sv
package trace_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic push;     // store one request in the queue
    logic pushSel;  // 1: write-debug-data source, 0: optional capture
    logic pop;      // move the queue head into the shifter
    logic advance;  // shift the active stream by one nibble
    logic busy;     // a stream is in the shifter
    logic first;    // shifter holds the first nibble of a stream
    logic halted;   // port is in the halted state
  } trcStrb_t;

  localparam logic [3:0] PST_IDLE   = 4'h0;
  localparam logic [3:0] PST_RETIRE = 4'h1;
  localparam logic [3:0] PST_HALT   = 4'hF;
  localparam logic [1:0] PST_MARK   = 2'b10;

endpackage

// File: rtl/trace_ctrl.sv
module trace_ctrl
  import trace_pkg::*;
#(
  parameter int NIBS    = 8,
  parameter int Q_DEPTH = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     instDone,
  input  logic     brkReq,
  input  logic     resumeReq,
  input  logic     capEnable,
  input  logic     capValid,
  input  logic     wddValid,
  output logic     wddStall,
  output trcStrb_t strb
);

  localparam int IDX_W = $clog2(NIBS);
  localparam int CNT_W = $clog2(Q_DEPTH + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NIBS - 1);

  logic [CNT_W-1:0] qCount;
  logic [IDX_W-1:0] nibIdx;
  logic busy, halted, pending;
  logic full, lastNib, popNow, pushW, pushC;

  always_comb begin
    full    = (qCount == CNT_W'(Q_DEPTH));
    lastNib = busy && (nibIdx == LAST_IDX);
    popNow  = !halted && (!busy || lastNib) && (qCount != '0);
    pushW   = wddValid && !full;
    pushC   = !wddValid && capValid && capEnable && !full;
  end

  assign wddStall = wddValid && full;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qCount <= '0;
    end else begin
      qCount <= qCount + CNT_W'(pushW || pushC) - CNT_W'(popNow);
    end
  end

  // stream progress, frozen while halted
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      nibIdx <= '0;
    end else if (!halted) begin
      if (popNow) begin
        busy   <= 1'b1;
        nibIdx <= '0;
      end else if (lastNib) begin
        busy <= 1'b0;
      end else if (busy) begin
        nibIdx <= nibIdx + 1'b1;
      end
    end
  end

  // breakpoint / halt sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halted  <= 1'b0;
      pending <= 1'b0;
    end else if (resumeReq) begin
      halted  <= 1'b0;
      pending <= 1'b0;
    end else if (!halted) begin
      if (instDone && (pending || brkReq)) begin
        halted  <= 1'b1;
        pending <= 1'b0;
      end else if (brkReq) begin
        pending <= 1'b1;
      end
    end
  end

  always_comb begin
    strb.push    = pushW || pushC;
    strb.pushSel = pushW;
    strb.pop     = popNow;
    strb.advance = busy && !halted;
    strb.busy    = busy;
    strb.first   = busy && (nibIdx == '0);
    strb.halted  = halted;
  end

endmodule

// File: rtl/trace_dp.sv
module trace_dp
  import trace_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int Q_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  trcStrb_t          strb,
  input  logic              instDone,
  input  logic [1:0]        capSize,
  input  logic [DATA_W-1:0] capData,
  input  logic [1:0]        wddSize,
  input  logic [DATA_W-1:0] wddData,
  input  logic [3:0]        bkptStatus,
  output logic [3:0]        pstOut,
  output logic [3:0]        ddOut
);

  localparam int ENT_W = DATA_W + 2;
  localparam int PTR_W = (Q_DEPTH > 1) ? $clog2(Q_DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(Q_DEPTH - 1);

  logic [ENT_W-1:0]  qMem [Q_DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [DATA_W-1:0] shData;
  logic [1:0]        shSize;
  logic [ENT_W-1:0]  headEnt;

  assign headEnt = qMem[rdPtr];

  always_ff @(posedge clk) begin
    if (strb.push) begin
      qMem[wrPtr] <= strb.pushSel ? {wddSize, wddData} : {capSize, capData};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.push) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (strb.pop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shData <= '0;
      shSize <= '0;
    end else if (strb.pop) begin
      shData <= headEnt[DATA_W-1:0];
      shSize <= headEnt[ENT_W-1:DATA_W];
    end else if (strb.advance) begin
      shData <= shData >> 4;
    end
  end

  // output lanes, one update per core cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pstOut <= PST_IDLE;
      ddOut  <= 4'h0;
    end else begin
      if (strb.halted)     pstOut <= PST_HALT;
      else if (strb.first) pstOut <= {PST_MARK, shSize};
      else if (instDone)   pstOut <= PST_RETIRE;
      else                 pstOut <= PST_IDLE;
      ddOut <= (strb.busy && !strb.halted) ? shData[3:0] : bkptStatus;
    end
  end

endmodule

// File: rtl/trace_port.sv
module trace_port
  import trace_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int Q_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instDone,
  input  logic              brkReq,
  input  logic              resumeReq,
  input  logic              capEnable,
  input  logic              capValid,
  input  logic [1:0]        capSize,
  input  logic [DATA_W-1:0] capData,
  input  logic              wddValid,
  input  logic [1:0]        wddSize,
  input  logic [DATA_W-1:0] wddData,
  output logic              wddStall,
  input  logic [3:0]        bkptStatus,
  output logic [3:0]        pstOut,
  output logic [3:0]        ddOut,
  output logic              trcStrobe
);

  localparam int NIBS = DATA_W / 4;

  trcStrb_t strb;
  logic loPhase, hiPhase;

  trace_ctrl #(.NIBS(NIBS), .Q_DEPTH(Q_DEPTH)) u_ctl (
    .clk(clk), .rstN(rstN), .instDone(instDone), .brkReq(brkReq),
    .resumeReq(resumeReq), .capEnable(capEnable), .capValid(capValid),
    .wddValid(wddValid), .wddStall(wddStall), .strb(strb)
  );

  trace_dp #(.DATA_W(DATA_W), .Q_DEPTH(Q_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .instDone(instDone),
    .capSize(capSize), .capData(capData), .wddSize(wddSize),
    .wddData(wddData), .bkptStatus(bkptStatus),
    .pstOut(pstOut), .ddOut(ddOut)
  );

  // half-cycle delayed strobe: low after rising edge, high after falling edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) loPhase <= 1'b0;
    else       loPhase <= !loPhase;
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) hiPhase <= 1'b0;
    else       hiPhase <= loPhase;
  end

  assign trcStrobe = !(hiPhase ^ loPhase);

endmodule

// File: rtl/trace_port_chk.sv
module trace_port_chk
  import trace_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       instDone,
  input logic       wddValid,
  input logic       wddStall,
  input logic [3:0] bkptStatus,
  input logic [3:0] pstOut,
  input logic [3:0] ddOut,
  input trcStrb_t   strb
);

  // R3
  halt_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.halted |=> pstOut == PST_HALT);

  // R3
  halt_on_retire_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.halted) |-> $past(instDone));

  // R8
  stall_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    wddStall |-> wddValid);

  // R7
  single_marker_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pstOut[3:2] == PST_MARK) |=> (pstOut[3:2] != PST_MARK));

  // R2
  idle_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.halted && !strb.first && !instDone) |=> pstOut == PST_IDLE);

  // R4
  default_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.busy || strb.halted) |=> ddOut == $past(bkptStatus));

endmodule

bind trace_port trace_port_chk u_chk (
  .clk(clk), .rstN(rstN), .instDone(instDone), .wddValid(wddValid),
  .wddStall(wddStall), .bkptStatus(bkptStatus), .pstOut(pstOut),
  .ddOut(ddOut), .strb(strb)
);

// File: tb/trace_port_bench.sv
`timescale 1ns/1ps
module trace_port_bench;

  localparam int DW   = 16;
  localparam int QD   = 2;
  localparam int NIBS = DW / 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          instDone = 0, brkReq = 0, resumeReq = 0, capEnable = 0;
  logic          capValid = 0, wddValid = 0;
  logic [1:0]    capSize = 0, wddSize = 0;
  logic [DW-1:0] capData = 0, wddData = 0;
  logic [3:0]    bkptStatus = 0;
  logic          wddStall, trcStrobe;
  logic [3:0]    pstOut, ddOut;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  trace_port #(.DATA_W(DW), .Q_DEPTH(QD)) u_trace_port (
    .clk(clk), .rstN(rstN), .instDone(instDone), .brkReq(brkReq),
    .resumeReq(resumeReq), .capEnable(capEnable), .capValid(capValid),
    .capSize(capSize), .capData(capData), .wddValid(wddValid),
    .wddSize(wddSize), .wddData(wddData), .wddStall(wddStall),
    .bkptStatus(bkptStatus), .pstOut(pstOut), .ddOut(ddOut),
    .trcStrobe(trcStrobe)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=%0d exp=<20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic clearReqs;
    instDone = 0; brkReq = 0; resumeReq = 0; capValid = 0; wddValid = 0;
  endtask

  task automatic expStream(input string tag, input logic [1:0] sz, input logic [DW-1:0] d);
    for (int i = 0; i < NIBS; i++) begin
      step;
      chk({tag, " pst"}, pstOut, (i == 0) ? {2'b10, sz} : 4'h0);
      chk({tag, " dd"}, ddOut, d[4*i +: 4]);
    end
  endtask

  initial begin
    logic [DW-1:0] dA, dB, dC;
    // R1 reset values
    @(negedge clk); @(negedge clk);
    chk("R1 reset pst", pstOut, 4'h0);
    chk("R1 reset dd", ddOut, 4'h0);
    chk("R8 reset stall", {3'b0, wddStall}, 4'h0);
    rstN = 1'b1;

    // R10 strobe phase
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #5;
      chk("R10 strobe first half", {3'b0, trcStrobe}, 4'h0);
      #10;
      chk("R10 strobe second half", {3'b0, trcStrobe}, 4'h1);
    end
    @(negedge clk);

    // R2 / R4 sweep of breakpoint status and retire
    for (int v = 0; v < 16; v++) begin
      bkptStatus = 4'(v);
      instDone = v[0];
      step;
      chk("R4 default data", ddOut, 4'(v));
      chk("R2 retire/idle code", pstOut, {3'b0, v[0]});
    end
    clearReqs;
    bkptStatus = 4'h5;

    // R5 optional capture ignored while disabled
    capEnable = 0; capValid = 1; capData = 16'hBEEF; capSize = 2'd3;
    step;
    clearReqs;
    for (int i = 0; i < 6; i++) begin
      step;
      chk("R5 disabled pst", pstOut, 4'h0);
      chk("R5 disabled dd", ddOut, 4'h5);
    end

    // R7 sweep over size codes and data patterns
    capEnable = 1;
    for (int sz = 0; sz < 4; sz++) begin
      for (int p = 0; p < 4; p++) begin
        dA = 16'(16'hA5C3 + p * 16'h1357 + sz * 16'h0F1E);
        capValid = 1; capSize = 2'(sz); capData = dA;
        step;
        clearReqs;
        step;
        chk("R7 latency pst", pstOut, 4'h0);
        chk("R7 latency dd", ddOut, 4'h5);
        expStream("R7 stream", 2'(sz), dA);
      end
    end
    step;
    chk("R7 after stream dd", ddOut, 4'h5);

    // R6 forced capture with enable off
    capEnable = 0;
    wddValid = 1; wddSize = 2'd2; wddData = 16'h9A3F;
    step;
    clearReqs;
    step;
    expStream("R6 forced", 2'd2, 16'h9A3F);

    // R6 priority: both requests together
    capEnable = 1;
    wddValid = 1; wddSize = 2'd1; wddData = 16'h1111;
    capValid = 1; capSize = 2'd3; capData = 16'h2222;
    step;
    clearReqs;
    step;
    expStream("R6 priority", 2'd1, 16'h1111);
    for (int i = 0; i < 6; i++) begin
      step;
      chk("R6 optional dropped pst", pstOut, 4'h0);
      chk("R6 optional dropped dd", ddOut, 4'h5);
    end

    // R8 queue fill, drop and stall
    dA = 16'h4321; dB = 16'h8765; dC = 16'hCBA9;
    capValid = 1; capSize = 2'd0; capData = dA;
    step;
    capSize = 2'd1; capData = dB;
    step;
    chk("R8 fill pst", pstOut, 4'h0);
    capSize = 2'd2; capData = dC;
    step;
    chk("R8 head marker", pstOut, 4'b1000);
    chk("R8 head nib0", ddOut, dA[3:0]);
    capSize = 2'd3; capData = 16'hDDDD;
    wddValid = 1; wddSize = 2'd3; wddData = 16'hEEEE;
    #1;
    chk("R8 stall when full", {3'b0, wddStall}, 4'h1);
    step;
    chk("R8 head nib1", ddOut, dA[7:4]);
    clearReqs;
    #1;
    chk("R8 stall released", {3'b0, wddStall}, 4'h0);
    step;
    chk("R8 head nib2", ddOut, dA[11:8]);
    step;
    chk("R8 head nib3", ddOut, dA[15:12]);
    expStream("R8 second", 2'd1, dB);
    expStream("R8 third", 2'd2, dC);
    step;
    chk("R8 dropped pst", pstOut, 4'h0);
    chk("R8 dropped dd", ddOut, 4'h5);
    step;
    chk("R8 dropped dd later", ddOut, 4'h5);

    // R3 halt waits for retirement
    capEnable = 0;
    brkReq = 1;
    step;
    chk("R3 request edge", pstOut, 4'h0);
    brkReq = 0;
    step;
    chk("R3 pending not halted", pstOut, 4'h0);
    instDone = 1;
    step;
    chk("R3 retire edge", pstOut, 4'h1);
    instDone = 0;
    step;
    chk("R3 halted code", pstOut, 4'hF);
    chk("R4 halted dd", ddOut, 4'h5);
    instDone = 1; brkReq = 1;
    step;
    chk("R3 ignore while halted", pstOut, 4'hF);
    clearReqs;
    step;
    chk("R3 still halted", pstOut, 4'hF);
    resumeReq = 1;
    step;
    chk("R3 resume edge", pstOut, 4'hF);
    resumeReq = 0;
    step;
    chk("R3 resumed idle", pstOut, 4'h0);
    instDone = 1;
    step;
    chk("R3 no stale halt", pstOut, 4'h1);
    clearReqs;
    step;
    chk("R3 no stale halt idle", pstOut, 4'h0);

    // R3 request and retirement on the same edge
    brkReq = 1; instDone = 1;
    step;
    chk("R3 same-edge retire", pstOut, 4'h1);
    clearReqs;
    step;
    chk("R3 same-edge halt", pstOut, 4'hF);
    resumeReq = 1;
    step;
    clearReqs;
    step;
    chk("R3 same-edge resumed", pstOut, 4'h0);

    // R9 stream frozen by halt
    capEnable = 1;
    capValid = 1; capSize = 2'd3; capData = 16'hC0DE;
    step;
    clearReqs;
    step;
    step;
    chk("R9 marker", pstOut, 4'hB);
    chk("R9 nib0", ddOut, 4'hE);
    brkReq = 1; instDone = 1;
    step;
    chk("R9 nib1 pst", pstOut, 4'h1);
    chk("R9 nib1", ddOut, 4'hD);
    clearReqs;
    step;
    chk("R9 halted pst", pstOut, 4'hF);
    chk("R9 halted dd", ddOut, 4'h5);
    step;
    chk("R9 frozen dd", ddOut, 4'h5);
    resumeReq = 1;
    step;
    chk("R9 resume edge pst", pstOut, 4'hF);
    clearReqs;
    step;
    chk("R9 resumed pst", pstOut, 4'h0);
    chk("R9 resumed nib2", ddOut, 4'h0);
    step;
    chk("R9 resumed nib3", ddOut, 4'hC);
    step;
    chk("R9 end dd", ddOut, 4'h5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule